// File: doc/BRIEF.md
# Disk Arm Seek Step Controller

This block runs the controller side of a disk arm seek. A seek command gives a cylinder count and a direction. The block then sends the drive a series of active-low access-go requests. Each request moves the arm by one or two cylinders. The drive answers each request through its access-ready line. Ready drops a few milliseconds after a request is raised and comes back high once the arm has settled. Each drop of ready ends one step. The block subtracts that step's size from the remaining count. When ready comes back high, the block raises the next request if cylinders remain.

The remaining count is held in inverted form, so an all-ones register means no cylinders are left. The step-size output is taken from the low bit of that register. An odd count therefore starts with one single-cylinder step. After the first step the low bit is forced to one, so every later step is a double step. An even count uses double steps from the start. Busy stays high from the moment a seek with a non-zero count is accepted until the count reaches zero. The drive's ready line is asynchronous and passes through a synchronizer before use.

Top module: `seek_step_ctrl`

## Requirements
- R1: After reset, busy is 0, access_go_n is 1, seek_dir is 0 and step_two is 1 (the count register holds all ones, meaning zero cylinders remain).
- R2: A cmd_strobe sampled while busy is 0 is accepted. If cmd_count is non-zero, busy reads 1 from the next cycle. If cmd_count is zero, busy stays 0 and no request is issued.
- R3: access_go_n is 0 only while busy is 1, the synchronized ready is 1 and the remaining count is non-zero. Right after an accept with ready already high, access_go_n reads 0 in the next cycle.
- R4: step_two equals the low bit of the inverted count: 0 selects a one-cylinder step and 1 selects a two-cylinder step. An odd count therefore makes its first request with step_two = 0, and an even count makes it with step_two = 1.
- R5: Once the first request of a seek has been released, step_two stays 1 for every later request of that seek.
- R6: Each fall of the synchronized ready while a request is active ends one step and lowers the remaining count by that step's size. A count n gives (n+1)/2 requests when n is odd and n/2 when n is even.
- R7: busy clears in the same cycle as the step that brings the remaining count to zero, and access_go_n is 1 from then on.
- R8: seek_dir takes the value of cmd_dir (bit 13 of the second command word) when a command is accepted, and holds it until the next accepted command.
- R9: A cmd_strobe sampled while busy is 1 is ignored. This includes the cycle in which the last step completes. It leaves seek_dir, the count and the request sequence unchanged.
- R10: A fall of ready while no seek is active has no effect on busy, access_go_n or the next seek's steps.
- R11: drv_ready passes through two flops, and access_go_n is updated on the following edge. A rise of drv_ready driven just before edge k shows as access_go_n = 0 after edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_strobe | input | 1 | Seek command strobe, one cycle |
| cmd_count | input | 16 | Number of cylinders to move |
| cmd_dir | input | 1 | Direction bit (bit 13 of the second command word) |
| drv_ready | input | 1 | Asynchronous access-ready feedback from the drive |
| access_go_n | output | 1 | Active-low step request to the drive |
| seek_dir | output | 1 | Direction of the current seek |
| step_two | output | 1 | 1 for a two-cylinder step, 0 for a one-cylinder step |
| busy | output | 1 | Seek in progress |

## Verification
Two events can land in the same clock cycle. One is the completion of the final step, which clears busy. The other is the arrival of a new seek command. The bench starts a one-cylinder seek and drops ready by hand, then places the strobe exactly on the cycle in which the synchronized fall is seen. It judges that the command was dropped: busy falls, access_go_n stays high, the direction keeps its old value, and no further request appears after ready returns.

// File: rtl/seek_pkg.sv
package seek_pkg;

  typedef enum logic {
    STEP_ONE = 1'b0,
    STEP_TWO = 1'b1
  } step_e;

  // Number of cylinders covered by one request of the given size
  function automatic logic [1:0] step_amount(input step_e sel);
    return (sel == STEP_TWO) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/seek_rdy_sync.sv
module seek_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_raw,
  output logic rdy_s,
  output logic rdy_fall
);

  logic [STAGES-1:0] sync_q;
  logic              hist_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], rdy_raw};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= rdy_raw;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= sync_q[STAGES-1];
  end

  assign rdy_s    = sync_q[STAGES-1];
  assign rdy_fall = hist_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/seek_count.sv
module seek_count
  import seek_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             step_done,
  output step_e            step_sel,
  output logic             rem_zero_nxt
);

  // Remaining cylinders kept inverted: all ones means nothing left
  logic [CNT_W-1:0] wcr_q, wcr_d;
  logic             wcr_en;

  always_comb begin
    wcr_d  = wcr_q;
    wcr_en = load | step_done;
    if (load) begin
      wcr_d = ~load_cnt;
    end else if (step_done) begin
      // ~(r - s) == ~r + s, so adding shrinks the remaining count
      wcr_d    = wcr_q + CNT_W'(step_amount(step_e'(wcr_q[0])));
      wcr_d[0] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wcr_q <= '1;
    else if (wcr_en) wcr_q <= wcr_d;
  end

  assign step_sel     = step_e'(wcr_q[0]);
  assign rem_zero_nxt = &wcr_d;

endmodule

// File: rtl/seek_ctrl.sv
module seek_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_strobe,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             cmd_dir,
  input  logic             rdy_s,
  input  logic             rdy_fall,
  input  logic             rem_zero_nxt,
  output logic             accept,
  output logic             step_done,
  output logic             busy,
  output logic             go,
  output logic             dir
);

  logic busy_q, busy_d;
  logic go_q, go_d;
  logic dir_q, dir_d;
  logic cnt_nz;

  assign cnt_nz    = |cmd_count;
  assign accept    = cmd_strobe & ~busy_q;
  assign step_done = busy_q & go_q & rdy_fall;

  always_comb begin
    busy_d = busy_q;
    if (accept && cnt_nz)              busy_d = 1'b1;
    else if (step_done && rem_zero_nxt) busy_d = 1'b0;
    go_d  = busy_d & rdy_s & ~rem_zero_nxt;
    dir_d = accept ? cmd_dir : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      go_q   <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      go_q   <= go_d;
      if (accept) dir_q <= dir_d;
    end
  end

  assign busy = busy_q;
  assign go   = go_q;
  assign dir  = dir_q;

endmodule

// File: rtl/seek_step_ctrl.sv
module seek_step_ctrl
  import seek_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_strobe,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             cmd_dir,
  input  logic             drv_ready,
  output logic             access_go_n,
  output logic             seek_dir,
  output logic             step_two,
  output logic             busy
);

  logic  rdy_s, rdy_fall;
  logic  accept, step_done, rem_zero_nxt, go;
  step_e step_sel;

  seek_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy_raw  (drv_ready),
    .rdy_s    (rdy_s),
    .rdy_fall (rdy_fall)
  );

  seek_count #(.CNT_W(CNT_W)) u_count (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (accept),
    .load_cnt     (cmd_count),
    .step_done    (step_done),
    .step_sel     (step_sel),
    .rem_zero_nxt (rem_zero_nxt)
  );

  seek_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_strobe   (cmd_strobe),
    .cmd_count    (cmd_count),
    .cmd_dir      (cmd_dir),
    .rdy_s        (rdy_s),
    .rdy_fall     (rdy_fall),
    .rem_zero_nxt (rem_zero_nxt),
    .accept       (accept),
    .step_done    (step_done),
    .busy         (busy),
    .go           (go),
    .dir          (seek_dir)
  );

  assign access_go_n = ~go;
  assign step_two    = (step_sel == STEP_TWO);

endmodule

// File: rtl/seek_step_ctrl_chk.sv
module seek_step_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_strobe,
  input logic [CNT_W-1:0] cmd_count,
  input logic             access_go_n,
  input logic             seek_dir,
  input logic             step_two,
  input logic             busy
);

  // R3: a request is only ever raised inside a seek
  a_r3_go_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !access_go_n |-> busy);

  // R7: when busy drops, no request remains
  a_r7_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> access_go_n);

  // R5: after any release the size is forced to two cylinders
  a_r5_two_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_go_n) |-> step_two);

  // R2: a zero-count command never starts a seek
  a_r2_zero_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && !busy && cmd_count == '0) |=> !busy);

  // R2: a non-zero command starts a seek
  a_r2_nonzero_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && !busy && cmd_count != '0) |=> busy);

  // R9: a strobe during a seek leaves the direction alone
  a_r9_busy_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_strobe) |=> $stable(seek_dir));

  // R8: direction holds for the whole seek
  a_r8_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(seek_dir));

endmodule

bind seek_step_ctrl seek_step_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_seek_step_ctrl.sv
module tb_seek_step_ctrl;

  localparam int D_FALL = 5;
  localparam int D_RISE = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_strobe = 1'b0;
  logic [15:0] cmd_count = '0;
  logic        cmd_dir = 1'b0;
  logic        model_en = 1'b0;
  logic        mdl_ready = 1'b1;
  logic        man_ready = 1'b0;
  logic        drv_ready;
  logic        access_go_n, seek_dir, step_two, busy;

  int total = 0;
  int bad   = 0;
  bit exp_q[$];

  assign drv_ready = model_en ? mdl_ready : man_ready;

  always #4 clk = ~clk;

  seek_step_ctrl dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_strobe  (cmd_strobe),
    .cmd_count   (cmd_count),
    .cmd_dir     (cmd_dir),
    .drv_ready   (drv_ready),
    .access_go_n (access_go_n),
    .seek_dir    (seek_dir),
    .step_two    (step_two),
    .busy        (busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Drive model: ready falls D_FALL cycles after a request, returns D_RISE later
  initial begin
    forever begin
      @(negedge clk);
      if (model_en && !access_go_n && mdl_ready) begin
        repeat (D_FALL) @(negedge clk);
        mdl_ready = 1'b0;
        repeat (D_RISE) @(negedge clk);
        mdl_ready = 1'b1;
      end
    end
  end

  // Monitor: each released request pops one expected step size (R4, R5, R6)
  initial begin
    bit prev_go = 1'b1;
    bit last_sz = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && !prev_go && access_go_n) begin
        if (exp_q.size() == 0) begin
          chk("R6 unexpected request", 1, 0);
        end else begin
          chk("R4/R5 step size", int'(last_sz), int'(exp_q.pop_front()));
        end
      end
      if (!access_go_n) last_sz = step_two;
      prev_go = access_go_n;
    end
  end

  task automatic push_plan(input int n);
    int rem = n;
    if (rem % 2 == 1) begin
      exp_q.push_back(1'b0);
      rem--;
    end
    for (int i = 0; i < rem / 2; i++) exp_q.push_back(1'b1);
  endtask

  task automatic start_seek(input int n, input bit d);
    push_plan(n);
    cmd_count  = 16'(n);
    cmd_dir    = d;
    cmd_strobe = 1'b1;
    @(negedge clk);
    cmd_strobe = 1'b0;
    chk("R2 busy after accept", int'(busy), (n != 0) ? 1 : 0);
    chk("R8 dir captured", int'(seek_dir), int'(d));
  endtask

  task automatic finish_seek(input bit d);
    int guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk("R7 busy cleared", int'(busy), 0);
    chk("R7 no request after done", int'(access_go_n), 1);
    chk("R6 all steps seen", exp_q.size(), 0);
    chk("R8 dir held", int'(seek_dir), int'(d));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 busy", int'(busy), 0);
    chk("R1 go_n", int'(access_go_n), 1);
    chk("R1 dir", int'(seek_dir), 0);
    chk("R1 step_two", int'(step_two), 1);

    // R10: ready toggles while idle
    man_ready = 1'b1;
    repeat (5) @(negedge clk);
    man_ready = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 busy idle", int'(busy), 0);
    chk("R10 go_n idle", int'(access_go_n), 1);

    // R2: zero count
    start_seek(0, 1'b1);
    repeat (4) @(negedge clk);
    chk("R2 zero count no busy", int'(busy), 0);
    chk("R2 zero count no request", int'(access_go_n), 1);

    // R11: synchronizer latency, ready low at accept
    start_seek(2, 1'b0);
    chk("R3 no request while ready low", int'(access_go_n), 1);
    man_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 not yet after two edges", int'(access_go_n), 1);
    @(negedge clk);
    chk("R11 request after three edges", int'(access_go_n), 0);
    chk("R4 even count two-step", int'(step_two), 1);
    man_ready = 1'b0;
    repeat (6) @(negedge clk);
    finish_seek(1'b0);
    man_ready = 1'b1;
    repeat (4) @(negedge clk);

    // R9: strobe on the very cycle the last step completes
    start_seek(1, 1'b1);
    chk("R3 request right after accept", int'(access_go_n), 0);
    chk("R4 odd count one-step", int'(step_two), 0);
    @(negedge clk);
    man_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cmd_count  = 16'd5;
    cmd_dir    = 1'b0;
    cmd_strobe = 1'b1;
    chk("R9 still busy at strobe", int'(busy), 1);
    @(negedge clk);
    cmd_strobe = 1'b0;
    chk("R9 busy cleared with strobe", int'(busy), 0);
    chk("R9 go released", int'(access_go_n), 1);
    chk("R9 dir kept", int'(seek_dir), 1);
    man_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 dropped command not started", int'(busy), 0);
    chk("R9 no request", int'(access_go_n), 1);
    chk("R6 queue after concurrent", exp_q.size(), 0);

    // Model-driven seeks
    model_en = 1'b1;
    start_seek(7, 1'b1);  finish_seek(1'b1);
    start_seek(8, 1'b0);  finish_seek(1'b0);
    start_seek(1, 1'b0);  finish_seek(1'b0);
    start_seek(33, 1'b1); finish_seek(1'b1);

    // R9: strobe mid-seek with a different count and direction
    start_seek(6, 1'b0);
    repeat (20) @(negedge clk);
    cmd_count  = 16'd20;
    cmd_dir    = 1'b1;
    cmd_strobe = 1'b1;
    @(negedge clk);
    cmd_strobe = 1'b0;
    chk("R9 dir unchanged mid-seek", int'(seek_dir), 0);
    finish_seek(1'b0);

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule